// File: doc/BRIEF.md
# Polled Serial Port with Split Baud Divider

This block is a byte-oriented asynchronous serial port that a processor drives entirely by polling a small register window. Software programs a 16-bit prescale count and an 8-bit per-bit sample count, enables the transmitter and receiver, then moves bytes by writing and reading a single data location while watching a status word for empty, full and busy conditions. Frames are fixed at one low start bit, eight data bits sent least significant first, and one high stop bit, with no parity.

The bit rate is the clock frequency divided by the product of the prescale count and one more than the sample count. The prescaler produces a sample tick, and both the transmitter and receiver spend exactly (sample count + 1) ticks on every bit. The receiver confirms a start bit halfway through it, then samples each later bit once per bit time, so the sampling point sits near the middle of each bit. Two 16-entry queues decouple software from the line, and two self-clearing control bits flush either direction independently.

Top module: `sio_core`

## Requirements
- R1: Registers sit at byte offsets control 0x00 (9 bits), mode 0x04 (11 bits), prescale 0x18 (16 bits), status 0x2C, data 0x30 and sample count 0x34 (8 bits); writable ones read back the written bits with upper bits zero; after reset control and mode read 0, prescale reads 0x028B and sample count reads 0x0F; unmapped offsets read 0.
- R2: Every bit on the transmit line lasts exactly prescale × (sample count + 1) clock cycles.
- R3: The transmit line idles high; a frame is a low start bit, eight data bits least significant first, and a high stop bit.
- R4: Status bit 1 reads 1 while the receive queue is empty; status bit 4 reads 1 while the transmit queue is full.
- R5: Status bit 11 reads 1 while the transmit queue holds a byte or a frame is being shifted out, and 0 otherwise.
- R6: Control bit 0 (receive reset) and bit 1 (transmit reset) read 1 in the cycle after they are written and 0 from then on; on clearing they empty their queue and return their engine to idle, with the transmit line driven high.
- R7: Control bit 4 enables the transmitter and bit 2 the receiver; with the transmitter disabled queued bytes stay queued and the line stays high; with the receiver disabled incoming frames are not stored.
- R8: A prescale value below 2 stops the sample tick, so no bit time advances and no frame starts until a valid value is written.
- R9: A write to 0x30 queues the low 8 bits of the write data; the transmit queue holds 16 bytes and a write while it is full is discarded.
- R10: A read of 0x30 returns and removes the oldest received byte, or returns 0 with no effect when the queue is empty; a frame completing while the 16-entry receive queue is full is discarded.
- R11: The receiver discards a low pulse that is gone at the middle of the start bit and discards a frame whose stop bit samples low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_rd | input | 1 | Register read strobe; a data read removes a received byte |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the same cycle |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line, synchronised inside |

## Verification
The bench measures the low time of an all-zero frame for several prescale and sample-count pairs, so a divider that used one term alone, or counted one tick too few per bit, gives a wrong cycle count. It loops the line back and sends every byte value, decoding the line bit by bit as well, which exposes swapped bit order or a missing stop bit. Queue edges are driven to exactly 16 and 17 entries in both directions, where an off-by-one depth would keep or lose the wrong byte, and the reset bits are read both in the cycle after the write and later, catching bits that never clear or never act. Short low glitches, a zero stop bit and a prescale of 0 or 1 are driven, where a receiver without the mid-start check or a prescaler that ticks on an invalid value would store or send a byte.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
  localparam logic [REG_AW-1:0] OFS_MODE = 6'h04;
  localparam logic [REG_AW-1:0] OFS_PRE  = 6'h18;
  localparam logic [REG_AW-1:0] OFS_STAT = 6'h2C;
  localparam logic [REG_AW-1:0] OFS_DATA = 6'h30;
  localparam logic [REG_AW-1:0] OFS_SMP  = 6'h34;

  localparam int unsigned CB_RXCLR = 0;
  localparam int unsigned CB_TXCLR = 1;
  localparam int unsigned CB_RXON  = 2;
  localparam int unsigned CB_TXON  = 4;

  localparam int unsigned SB_RXEMPTY = 1;
  localparam int unsigned SB_TXFULL  = 4;
  localparam int unsigned SB_TXBUSY  = 11;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign rdata   = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> $stable(cnt_q));
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CD_W-1:0] cd_i,
  output logic            tick_o
);
  logic [CD_W-1:0] cnt_q, cnt_d;
  logic            cd_ok;

  assign cd_ok = (cd_i >= CD_W'(2));

  always_comb begin
    tick_o = 1'b0;
    cnt_d  = cnt_q;
    if (!cd_ok) begin
      cnt_d = '0;
    end else if (cnt_q >= cd_i - CD_W'(1)) begin
      cnt_d  = '0;
      tick_o = 1'b1;
    end else begin
      cnt_d = cnt_q + CD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cd_ok |=> (cnt_q == '0));
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DW     = 8,
  parameter int BDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  input  logic              avail_i,
  input  logic [DW-1:0]     data_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              line_o
);
  localparam int FW = DW + 2;
  localparam int IW = $clog2(FW);

  logic              busy_q, busy_d;
  logic [FW-1:0]     sh_q, sh_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [BDIV_W-1:0] sub_q, sub_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    sub_d  = sub_q;
    pop_o  = 1'b0;
    if (flush_i) begin
      busy_d = 1'b0;
      idx_d  = '0;
      sub_d  = '0;
    end else if (tick_i) begin
      if (!busy_q) begin
        if (en_i && avail_i) begin
          pop_o  = 1'b1;
          busy_d = 1'b1;
          sh_d   = {1'b1, data_i, 1'b0};
          idx_d  = '0;
          sub_d  = '0;
        end
      end else if (sub_q >= bdiv_i) begin
        sub_d = '0;
        if (idx_q == IW'(FW - 1)) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + IW'(1);
          sh_d  = {1'b1, sh_q[FW-1:1]};
        end
      end else begin
        sub_d = sub_q + BDIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      sub_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      sub_q  <= sub_d;
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;

  assert_flush_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> line_o);
  assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i && !flush_i) |=> $stable(line_o));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [BDIV_W-1:0] bdiv_i,
  input  logic              line_i,
  output logic              push_o,
  output logic [DW-1:0]     data_o
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  logic [1:0]        sync_q;
  rx_state_e         st_q, st_d;
  logic [BDIV_W-1:0] sub_q, sub_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DW-1:0]     sh_q, sh_d;
  logic              bit_in;

  assign bit_in = sync_q[1];
  assign data_o = sh_q;

  always_comb begin
    st_d   = st_q;
    sub_d  = sub_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    push_o = 1'b0;
    if (flush_i) begin
      st_d  = RX_IDLE;
      sub_d = '0;
      idx_d = '0;
    end else if (tick_i) begin
      unique case (st_q)
        RX_IDLE: begin
          if (en_i && !bit_in) begin
            st_d  = RX_START;
            sub_d = '0;
          end
        end
        RX_START: begin
          if (sub_q >= (bdiv_i >> 1)) begin
            st_d  = bit_in ? RX_IDLE : RX_DATA;
            sub_d = '0;
            idx_d = '0;
          end else begin
            sub_d = sub_q + BDIV_W'(1);
          end
        end
        RX_DATA: begin
          if (sub_q >= bdiv_i) begin
            sub_d = '0;
            sh_d  = {bit_in, sh_q[DW-1:1]};
            if (idx_q == IW'(DW - 1)) st_d = RX_STOP;
            else                      idx_d = idx_q + IW'(1);
          end else begin
            sub_d = sub_q + BDIV_W'(1);
          end
        end
        RX_STOP: begin
          if (sub_q >= bdiv_i) begin
            push_o = bit_in;
            st_d   = RX_IDLE;
            sub_d  = '0;
          end else begin
            sub_d = sub_q + BDIV_W'(1);
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      sub_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      st_q   <= st_d;
      sub_q  <= sub_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
    end
  end

  assert_rx_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && st_q == RX_IDLE) |=> (st_q == RX_IDLE));
  assert_rx_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (st_q == RX_IDLE));
  assert_push_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> (st_q == RX_IDLE));
endmodule

// File: rtl/sio_core.sv
module sio_core
  import sio_pkg::*;
#(
  parameter int              CD_W       = 16,
  parameter int              BDIV_W     = 8,
  parameter int              DATA_W     = 8,
  parameter int              FIFO_DEPTH = 16,
  parameter logic [CD_W-1:0]   CD_RST   = 16'h028B,
  parameter logic [BDIV_W-1:0] BDIV_RST = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ser_tx,
  input  logic              ser_rx
);
  localparam int CTRL_W = 9;
  localparam int MODE_W = 11;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [CD_W-1:0]   cd_q, cd_d;
  logic [BDIV_W-1:0] bdiv_q, bdiv_d;

  logic              wr_ctrl, rd_data;
  logic              tick;
  logic              txf_push, txf_pop, txf_empty, txf_full;
  logic [DATA_W-1:0] txf_rdata;
  logic              rxf_push, rxf_empty, rxf_full;
  logic [DATA_W-1:0] rxf_rdata, rx_byte;
  logic              tx_busy;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[31:16];
  assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
  assign txf_push = bus_wr && (bus_addr == OFS_DATA);
  assign rd_data  = bus_rd && (bus_addr == OFS_DATA);

  always_comb begin
    ctrl_d = ctrl_q;
    ctrl_d[CB_RXCLR] = 1'b0;
    ctrl_d[CB_TXCLR] = 1'b0;
    mode_d = mode_q;
    cd_d   = cd_q;
    bdiv_d = bdiv_q;
    if (bus_wr) begin
      unique case (bus_addr)
        OFS_CTRL: ctrl_d = bus_wdata[CTRL_W-1:0];
        OFS_MODE: mode_d = bus_wdata[MODE_W-1:0];
        OFS_PRE:  cd_d   = bus_wdata[CD_W-1:0];
        OFS_SMP:  bdiv_d = bus_wdata[BDIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= '0;
      cd_q   <= CD_RST;
      bdiv_q <= BDIV_RST;
    end else begin
      ctrl_q <= ctrl_d;
      mode_q <= mode_d;
      cd_q   <= cd_d;
      bdiv_q <= bdiv_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      OFS_MODE: bus_rdata[MODE_W-1:0] = mode_q;
      OFS_PRE:  bus_rdata[CD_W-1:0]   = cd_q;
      OFS_SMP:  bus_rdata[BDIV_W-1:0] = bdiv_q;
      OFS_STAT: begin
        bus_rdata[SB_RXEMPTY] = rxf_empty;
        bus_rdata[SB_TXFULL]  = txf_full;
        bus_rdata[SB_TXBUSY]  = tx_busy | ~txf_empty;
      end
      OFS_DATA: bus_rdata[DATA_W-1:0] = rxf_empty ? '0 : rxf_rdata;
      default: ;
    endcase
  end

  sio_baud #(.CD_W(CD_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .cd_i   (cd_q),
    .tick_o (tick)
  );

  sio_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ctrl_q[CB_TXCLR]),
    .push  (txf_push),
    .wdata (bus_wdata[DATA_W-1:0]),
    .pop   (txf_pop),
    .rdata (txf_rdata),
    .empty (txf_empty),
    .full  (txf_full)
  );

  sio_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ctrl_q[CB_RXCLR]),
    .push  (rxf_push),
    .wdata (rx_byte),
    .pop   (rd_data),
    .rdata (rxf_rdata),
    .empty (rxf_empty),
    .full  (rxf_full)
  );

  sio_tx #(.DW(DATA_W), .BDIV_W(BDIV_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (ctrl_q[CB_TXCLR]),
    .en_i    (ctrl_q[CB_TXON]),
    .tick_i  (tick),
    .bdiv_i  (bdiv_q),
    .avail_i (~txf_empty),
    .data_i  (txf_rdata),
    .pop_o   (txf_pop),
    .busy_o  (tx_busy),
    .line_o  (ser_tx)
  );

  sio_rx #(.DW(DATA_W), .BDIV_W(BDIV_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (ctrl_q[CB_RXCLR]),
    .en_i    (ctrl_q[CB_RXON]),
    .tick_i  (tick),
    .bdiv_i  (bdiv_q),
    .line_i  (ser_rx),
    .push_o  (rxf_push),
    .data_o  (rx_byte)
  );

  assert_clr_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_TXCLR] || ctrl_q[CB_RXCLR]) |=>
      ((!ctrl_q[CB_TXCLR] && !ctrl_q[CB_RXCLR]) || $past(wr_ctrl)));
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rxf_empty) |-> (bus_rdata == '0));
  assert_full_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_full && !txf_pop && !ctrl_q[CB_TXCLR]) |=> txf_full);
endmodule

// File: tb/sio_core_tb.sv
module sio_core_tb;
  localparam logic [5:0] A_CTRL = 6'h00;
  localparam logic [5:0] A_MODE = 6'h04;
  localparam logic [5:0] A_PRE  = 6'h18;
  localparam logic [5:0] A_STAT = 6'h2C;
  localparam logic [5:0] A_DATA = 6'h30;
  localparam logic [5:0] A_SMP  = 6'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_tx;
  logic        ser_rx;
  logic        loop_en = 1'b1;
  logic        rx_drv = 1'b1;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;
  assign ser_rx = loop_en ? ser_tx : rx_drv;

  sio_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ser_tx    (ser_tx),
    .ser_rx    (ser_rx)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_tx_idle();
    logic [31:0] s;
    do rd(A_STAT, s); while (s[11]);
  endtask

  task automatic wait_rx_data();
    logic [31:0] s;
    do rd(A_STAT, s); while (s[1]);
  endtask

  task automatic decode_line(input int p, output logic [9:0] f);
    while (ser_tx) @(negedge clk);
    repeat (p / 2) @(negedge clk);
    for (int b = 0; b < 10; b++) begin
      f[b] = ser_tx;
      if (b < 9) repeat (p) @(negedge clk);
    end
  endtask

  task automatic drive_rx(input logic [7:0] v, input logic stop, input int p);
    logic [9:0] fr;
    fr = {stop, v, 1'b0};
    for (int b = 0; b < 10; b++) begin
      @(negedge clk); rx_drv = fr[b];
      repeat (p - 1) @(negedge clk);
    end
    @(negedge clk); rx_drv = 1'b1;
  endtask

  task automatic line_stays_high(input string tag, input int n);
    int lows;
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!ser_tx) lows++;
    end
    chk(tag, lows, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [9:0]  f;
    int          n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 / R4 / R3: reset state
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 32'h0);
    rd(A_MODE, d); chk("R1 mode reset", d, 32'h0);
    rd(A_PRE, d);  chk("R1 prescale reset", d, 32'h028B);
    rd(A_SMP, d);  chk("R1 sample reset", d, 32'h0F);
    rd(A_STAT, d); chk("R4 status reset", d, 32'h002);
    rd(6'h08, d);  chk("R1 unmapped", d, 32'h0);
    chk("R3 idle high", {31'b0, ser_tx}, 32'h1);

    // R1: readback with width masking
    wr(A_MODE, 32'h20);        rd(A_MODE, d); chk("R1 mode 0x20", d, 32'h20);
    wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, d); chk("R1 mode mask", d, 32'h7FF);
    wr(A_PRE, 32'hFFFF_1234);  rd(A_PRE, d);  chk("R1 prescale mask", d, 32'h1234);
    wr(A_SMP, 32'h0000_01A5);  rd(A_SMP, d);  chk("R1 sample mask", d, 32'hA5);
    wr(A_CTRL, 32'hFFFF_FFEC); rd(A_CTRL, d); chk("R1 ctrl mask", d, 32'h1EC);
    wr(A_CTRL, 32'h0);
    wr(A_MODE, 32'h20);

    // R2: bit time sweep measured on an all-zero byte (9 low bits)
    for (int k = 0; k < 5; k++) begin
      int cd, bd;
      cd = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 5 : (k == 3) ? 2 : 7;
      bd = (k == 0) ? 4 : (k == 1) ? 5 : (k == 2) ? 7 : (k == 3) ? 15 : 4;
      wr(A_PRE, cd); wr(A_SMP, bd); wr(A_CTRL, 32'h10);
      wr(A_DATA, 32'h00);
      while (ser_tx) @(negedge clk);
      n = 0;
      while (!ser_tx) begin n++; @(negedge clk); end
      chk($sformatf("R2 low time cd=%0d bdiv=%0d", cd, bd), n, 9 * cd * (bd + 1));
      wr(A_DATA, 32'hFF);
      while (ser_tx) @(negedge clk);
      n = 0;
      while (!ser_tx) begin n++; @(negedge clk); end
      chk($sformatf("R2 start bit cd=%0d bdiv=%0d", cd, bd), n, cd * (bd + 1));
      wait_tx_idle();
    end

    // R3 / R9 / R10: all 256 byte values, decoded on the line and looped back
    wr(A_PRE, 2); wr(A_SMP, 4); wr(A_CTRL, 32'h14);
    for (int v = 0; v < 256; v++) begin
      wr(A_DATA, 32'hDEAD_BE00 | v);
      decode_line(10, f);
      chk($sformatf("R3 frame %02h", v), f, {1'b1, v[7:0], 1'b0});
      wait_rx_data();
      rd(A_DATA, d);
      chk($sformatf("R10 loopback %02h", v), d, v);
    end
    wait_tx_idle();
    rd(A_STAT, d); chk("R5 idle after sweep", d, 32'h002);

    // R7 / R9 / R4 / R5: transmitter disabled, fill queue to 16 and 17
    wr(A_CTRL, 32'h04);
    for (int i = 0; i < 16; i++) begin
      rd(A_STAT, d);
      chk($sformatf("R4 not full at %0d", i), d[4], 1'b0);
      wr(A_DATA, 32'hABCD_1200 | (32'h40 + i));
    end
    rd(A_STAT, d); chk("R4 full at 16", d[4], 1'b1);
    chk("R5 busy with queued bytes", d[11], 1'b1);
    wr(A_DATA, 32'hEE);
    line_stays_high("R7 tx disabled line idle", 150);
    wr(A_CTRL, 32'h14);
    wait_tx_idle();
    repeat (40) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, d); chk($sformatf("R9 queued byte %0d", i), d, 32'h40 + i);
    end
    rd(A_DATA, d); chk("R9 17th write dropped / R10 empty read", d, 32'h0);
    rd(A_STAT, d); chk("R4 rx empty after drain", d[1], 1'b1);

    // R10: receive queue overflow drops the 17th frame
    for (int i = 0; i < 17; i++) begin
      do rd(A_STAT, d); while (d[4]);
      wr(A_DATA, 32'h80 + i);
    end
    wait_tx_idle();
    repeat (40) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rd(A_DATA, d); chk($sformatf("R10 rx byte %0d", i), d, 32'h80 + i);
    end
    rd(A_DATA, d); chk("R10 17th frame dropped", d, 32'h0);

    // R6: transmit reset with queued bytes
    wr(A_CTRL, 32'h04);
    for (int i = 0; i < 5; i++) wr(A_DATA, 32'h11 * i);
    wr(A_CTRL, 32'h06);
    #1 chk("R6 txclr visible one cycle", bus_rdata, 32'h06);
    rd(A_CTRL, d); chk("R6 txclr self-clears", d, 32'h04);
    rd(A_STAT, d); chk("R6 tx queue flushed", d & 32'h810, 32'h0);
    wr(A_CTRL, 32'h14);
    line_stays_high("R6 nothing left to send", 200);

    // R6: transmit reset in mid-frame forces the line high
    wr(A_DATA, 32'h00);
    while (ser_tx) @(negedge clk);
    wr(A_CTRL, 32'h16);
    repeat (2) @(negedge clk);
    chk("R6 line high after mid-frame clear", {31'b0, ser_tx}, 32'h1);
    line_stays_high("R6 stays idle", 100);
    repeat (40) @(negedge clk);

    // R6: receive reset flushes stored bytes
    wr(A_CTRL, 32'h14);
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'h30 + i);
    wait_tx_idle();
    repeat (40) @(negedge clk);
    rd(A_STAT, d); chk("R4 rx not empty", d[1], 1'b0);
    wr(A_CTRL, 32'h15);
    #1 chk("R6 rxclr visible one cycle", bus_rdata, 32'h15);
    rd(A_STAT, d); chk("R6 rx flushed", d[1], 1'b1);
    rd(A_DATA, d); chk("R6 rx read after flush", d, 32'h0);
    rd(A_CTRL, d); chk("R6 rxclr self-clears", d, 32'h14);

    // R7: receiver disabled ignores frames
    wr(A_CTRL, 32'h10);
    wr(A_DATA, 32'h5A);
    wait_tx_idle();
    repeat (40) @(negedge clk);
    rd(A_STAT, d); chk("R7 rx disabled stores nothing", d[1], 1'b1);

    // R8: prescale 1 and 0 hold the transmitter
    for (int c = 1; c >= 0; c--) begin
      wr(A_PRE, c);
      wr(A_DATA, 32'h3C);
      line_stays_high($sformatf("R8 no tick prescale=%0d", c), 300);
      rd(A_STAT, d); chk($sformatf("R8 byte still pending prescale=%0d", c), d[11], 1'b1);
      wr(A_PRE, 2);
      decode_line(10, f);
      chk($sformatf("R8 sends after valid prescale=%0d", c), f, {1'b1, 8'h3C, 1'b0});
      wait_tx_idle();
    end

    // R11: glitch, bad stop bit, then a good externally driven frame
    loop_en = 1'b0;
    wr(A_CTRL, 32'h04);
    @(negedge clk); rx_drv = 1'b0;
    repeat (2) @(negedge clk); rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    rd(A_STAT, d); chk("R11 glitch ignored", d[1], 1'b1);
    drive_rx(8'h5A, 1'b0, 10);
    repeat (100) @(negedge clk);
    rd(A_STAT, d); chk("R11 low stop bit dropped", d[1], 1'b1);
    drive_rx(8'hC3, 1'b1, 10);
    repeat (40) @(negedge clk);
    rd(A_DATA, d); chk("R11 valid frame received", d, 32'hC3);

    finished = 1'b1;
    report();
  end
endmodule